// File: doc/BRIEF.md
# Ring Oscillator Pair Comparator

This block turns a bank of free-running ring oscillator outputs into one device-unique response bit. A challenge value names a pair of oscillators. On a start pulse the block counts the rising edges of both members of the pair over a fixed number of system-clock cycles. It then reports which member counted more edges.

The response comes from comparing the two counts directly, so no division is needed. A drift in supply or temperature speeds up or slows down both oscillators together, and the comparison cancels that common scaling. Each oscillator input is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector before any counter sees it. Oscillators are grouped into disjoint pairs, so a bank of N oscillators gives N/2 challenges. Any challenge outside that range is refused.

When the counts are equal, the block flags the result so that later logic can discard the bit. The counters stop at their top value rather than wrapping, so an overflow cannot reverse the outcome.

Top module: `ro_puf_eval`

## Requirements
- R1: Challenge value c, with 0 <= c < NUM_OSC/2, selects oscillator 2c as side A and oscillator 2c+1 as side B. Other oscillators have no effect on the result.
- R2: A start accepted in the idle state clears both counters and opens a window of WIN_CYCLES clock cycles. `done` is high for exactly one cycle, sampled WIN_CYCLES+1 rising edges after the edge that accepted the start.
- R3: With `done`, `response` is 1 when side A counted more rising edges than side B in the window, and 0 otherwise.
- R4: When both counts are equal, `response` is 0 and `tie` is 1. Otherwise `tie` is 0.
- R5: Each counter saturates at 2^CNT_W-1. A side whose true edge count exceeds that value still compares as greater than a side below it. Two saturated sides report a tie.
- R6: A start pulse that arrives while a measurement is running is ignored. The pending result, the `done` timing and the selected pair are unchanged, and `err` stays 0.
- R7: A start in the idle state with a challenge of NUM_OSC/2 or more raises `err` for one cycle, on the edge after it is sampled. No measurement starts and no `done` follows.
- R8: After reset, `done`, `response`, `tie` and `err` are all 0.
- R9: `response` and `tie` keep their values between `done` pulses, including across refused starts.
- R10: Each oscillator input is synchronized by two flip-flops, and each rising edge of an input slower than half the clock frequency is counted once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a measurement |
| challenge | input | CHAL_W | Pair index; values of NUM_OSC/2 or more are invalid |
| osc_in | input | NUM_OSC | Asynchronous oscillator outputs |
| done | output | 1 | One-cycle strobe when a result is ready |
| response | output | 1 | 1 when side A counted more edges than side B |
| tie | output | 1 | Counts were equal; the response bit is unreliable |
| err | output | 1 | One-cycle flag for a refused out-of-range challenge |

## Verification
The bench sweeps every pair index. For each one it sets side A faster than side B while every other pair runs the opposite way, so a mux that picks a wrong or swapped pair flips the bit. It repeats the sweep with the ordering reversed and with both inputs tied to one source, where any miscounted edge turns a tie into a spurious bit. It also drives a side fast enough to pass the counter's top value against a slower side. A wrapping counter would drop below the slower side and invert the response. The bench also fires starts mid-window with a different pair or an invalid value, which a design that re-arms or re-latches would answer late or with the wrong bit. Last, it sweeps all invalid challenges and checks that none of them produces a `done` or disturbs the held result.

// File: rtl/ropuf_pkg.sv
`timescale 1ns/1ps
package ropuf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CMP  = 2'd2
  } meas_state_t;

endpackage

// File: rtl/ro_sync_edge.sv
`timescale 1ns/1ps
module ro_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // R10
  rise_level_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> last_q);

endmodule

// File: rtl/ro_sat_counter.sv
`timescale 1ns/1ps
module ro_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc && count != TOP)
      count <= count + 1'b1;
  end

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> count >= $past(count));

endmodule

// File: rtl/ro_window_ctrl.sv
`timescale 1ns/1ps
module ro_window_ctrl
  import ropuf_pkg::*;
#(
  parameter int NUM_PAIRS  = 8,
  parameter int CHAL_W     = 4,
  parameter int WIN_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CHAL_W-1:0] challenge,
  output logic [CHAL_W-1:0] pair_sel,
  output logic              clr,
  output logic              count_en,
  output logic              cmp_strobe,
  output logic              err
);

  localparam int WIN_W = $clog2(WIN_CYCLES + 1);
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYCLES - 1);

  meas_state_t      state;
  logic [WIN_W-1:0] win_q;
  logic             chal_ok;
  logic             accept;

  assign chal_ok = ({1'b0, challenge} < (CHAL_W+1)'(NUM_PAIRS));
  assign accept  = start && (state == ST_IDLE) && chal_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      win_q    <= '0;
      pair_sel <= '0;
      err      <= 1'b0;
    end else begin
      err <= start && (state == ST_IDLE) && !chal_ok;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_RUN;
            win_q    <= '0;
            pair_sel <= challenge;
          end
        end
        ST_RUN: begin
          win_q <= win_q + 1'b1;
          if (win_q == LAST)
            state <= ST_CMP;
        end
        ST_CMP:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign clr        = accept;
  assign count_en   = (state == ST_RUN);
  assign cmp_strobe = (state == ST_CMP);

  // R2
  win_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (win_q <= LAST));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && state != ST_IDLE) |=> !err);

  // R7
  reject_chk: assert property (@(posedge clk) disable iff (rst)
    (start && state == ST_IDLE && !chal_ok) |=> (err && state == ST_IDLE));

endmodule

// File: rtl/ro_puf_eval.sv
`timescale 1ns/1ps
module ro_puf_eval #(
  parameter int NUM_OSC    = 16,
  parameter int CHAL_W     = $clog2(NUM_OSC),
  parameter int CNT_W      = 16,
  parameter int WIN_CYCLES = 4096,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CHAL_W-1:0]  challenge,
  input  logic [NUM_OSC-1:0] osc_in,
  output logic               done,
  output logic               response,
  output logic               tie,
  output logic               err
);

  localparam int NUM_PAIRS = NUM_OSC / 2;

  logic [NUM_OSC-1:0] rise_vec;
  logic [CHAL_W-1:0]  pair_sel;
  logic               clr, count_en, cmp_strobe;
  logic               rise_a, rise_b;
  logic [CNT_W-1:0]   cnt_a, cnt_b;

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
    ro_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (osc_in[i]),
      .rise     (rise_vec[i])
    );
  end

  always_comb begin
    rise_a = 1'b0;
    rise_b = 1'b0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (pair_sel == CHAL_W'(p)) begin
        rise_a = rise_vec[2*p];
        rise_b = rise_vec[2*p+1];
      end
    end
  end

  ro_window_ctrl #(
    .NUM_PAIRS  (NUM_PAIRS),
    .CHAL_W     (CHAL_W),
    .WIN_CYCLES (WIN_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .challenge  (challenge),
    .pair_sel   (pair_sel),
    .clr        (clr),
    .count_en   (count_en),
    .cmp_strobe (cmp_strobe),
    .err        (err)
  );

  ro_sat_counter #(.W(CNT_W)) u_cnt_a (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .inc   (rise_a & count_en),
    .count (cnt_a)
  );

  ro_sat_counter #(.W(CNT_W)) u_cnt_b (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .inc   (rise_b & count_en),
    .count (cnt_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      response <= 1'b0;
      tie      <= 1'b0;
    end else begin
      done <= cmp_strobe;
      if (cmp_strobe) begin
        response <= (cnt_a > cnt_b);
        tie      <= (cnt_a == cnt_b);
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  tie_zero_chk: assert property (@(posedge clk) disable iff (rst)
    tie |-> !response);

  // R7
  err_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(err && done));

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(response) && $stable(tie)));

endmodule

// File: tb/tb_ro_puf_eval.sv
`timescale 1ns/1ps
module tb_ro_puf_eval;

  localparam real CLK_PERIOD = 10.0;
  localparam int  N     = 8;
  localparam int  PAIRS = N / 2;
  localparam int  CW    = 3;
  localparam int  CNT_W = 5;
  localparam int  WIN   = 96;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] chal = '0;
  logic          tie_mode = 1'b0;
  real           half_ns [N] = '{default: 20.0};
  wire  [N-1:0]  osc_raw;
  wire  [N-1:0]  osc_bus;
  logic          done, response, tie, err;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic o;
    initial begin
      o = 1'b0;
      #0.5;
      forever begin
        #(half_ns[i]);
        o = ~o;
      end
    end
    assign osc_raw[i] = o;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_bus
    assign osc_bus[2*p]   = osc_raw[2*p];
    assign osc_bus[2*p+1] = tie_mode ? osc_raw[2*p] : osc_raw[2*p+1];
  end

  ro_puf_eval #(
    .NUM_OSC    (N),
    .CHAL_W     (CW),
    .CNT_W      (CNT_W),
    .WIN_CYCLES (WIN)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .challenge (chal),
    .osc_in    (osc_bus),
    .done      (done),
    .response  (response),
    .tie       (tie),
    .err       (err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_pair(input int p, input real ha, input real hb);
    half_ns[2*p]   = ha;
    half_ns[2*p+1] = hb;
  endtask

  // every pair: B faster than A, so a wrong pair gives response 0
  task automatic set_all_reversed();
    for (int p = 0; p < PAIRS; p++) set_pair(p, 30.0, 15.0);
  endtask

  task automatic measure(input int c, input bit exp_r, input bit exp_t,
                         input string req, input bit inj, input int inj_c);
    int k;
    @(negedge clk);
    chal  = CW'(c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (k = 1; k <= WIN + 10; k++) begin
      @(negedge clk);
      if (inj && k == 20) begin
        chal  = CW'(inj_c);
        start = 1'b1;
      end
      if (inj && k == 21) begin
        start = 1'b0;
        check(err == 1'b0, "R6 err on busy start", int'(err), 0);
      end
      if (done) break;
    end
    check(k == WIN + 1, {req, " R2 done cycle"}, k, WIN + 1);
    check(response == exp_r, {req, " response"}, int'(response), int'(exp_r));
    check(tie == exp_t, {req, " tie"}, int'(tie), int'(exp_t));
    @(negedge clk);
    check(done == 1'b0, "R2 done width", int'(done), 0);
  endtask

  task automatic reject(input int c);
    bit seen;
    bit r_prev, t_prev;
    r_prev = response;
    t_prev = tie;
    seen   = 1'b0;
    @(negedge clk);
    chal  = CW'(c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1, "R7 err raised", int'(err), 1);
    @(negedge clk);
    check(err == 1'b0, "R7 err one cycle", int'(err), 0);
    for (int k = 0; k < WIN + 10; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(!seen, "R7 no done after reject", int'(seen), 0);
    check(response == r_prev && tie == t_prev, "R9 result held",
          int'({response, tie}), int'({r_prev, t_prev}));
  endtask

  initial begin
    #(CLK_PERIOD * 200000.0);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R8 reset values
    check(done == 1'b0, "R8 done", int'(done), 0);
    check(response == 1'b0, "R8 response", int'(response), 0);
    check(tie == 1'b0, "R8 tie", int'(tie), 0);
    check(err == 1'b0, "R8 err", int'(err), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    for (int p = 0; p < PAIRS; p++) begin
      // R1 R3: A period 40 ns (24 edges), B 60 ns (16 edges)
      set_all_reversed();
      set_pair(p, 20.0, 30.0);
      measure(p, 1'b1, 1'b0, "R1 R3 A faster", 1'b0, 0);
      set_pair(p, 30.0, 20.0);
      measure(p, 1'b0, 1'b0, "R3 B faster", 1'b0, 0);
      // R4 R10: both sides see one source, counts match exactly
      tie_mode = 1'b1;
      measure(p, 1'b0, 1'b1, "R4 R10 tie", 1'b0, 0);
      tie_mode = 1'b0;
    end

    // R3 close frequencies: 24 vs about 21 edges
    set_pair(0, 20.0, 22.5);
    measure(0, 1'b1, 1'b0, "R3 close", 1'b0, 0);

    // R5: A ~38 edges saturates at 31, B 19; wrapping would give 6
    set_pair(1, 12.5, 25.0);
    measure(1, 1'b1, 1'b0, "R5 A saturated", 1'b0, 0);
    set_pair(2, 25.0, 12.5);
    measure(2, 1'b0, 1'b0, "R5 B saturated", 1'b0, 0);
    set_pair(3, 12.5, 13.75);
    measure(3, 1'b0, 1'b1, "R5 both saturated", 1'b0, 0);

    // R6: start mid-window with another pair or an invalid value
    set_all_reversed();
    set_pair(0, 20.0, 30.0);
    measure(0, 1'b1, 1'b0, "R6 busy start pair", 1'b1, 1);
    measure(0, 1'b1, 1'b0, "R6 busy start invalid", 1'b1, 6);

    // R7 R9: every invalid challenge is refused
    for (int c = PAIRS; c < (1 << CW); c++) reject(c);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule